// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block tracks and sequences the low-power states of a processor core that holds several logical processors (lanes) behind one stop-clock pin. The states are Normal, HALT, Stop-Grant and Sleep. The block runs on the bus clock. Its inputs are a stop-clock request, a sleep request, one halt indication per lane, one acknowledge-response pulse per lane and a wake input. The acknowledge-response pulse marks the response phase of the stop-grant acknowledge bus cycle that the lane issued.

Each lane has its own timer. The timer starts at that lane's acknowledge response and grants the lane a fixed number of bus clocks later. The core enters Stop-Grant only when every lane has been granted. Sleep can be entered only from Stop-Grant. While in Sleep, the internal clock-gate enable is driven low. Two sticky flags report protocol misuse: a stop-clock release before Stop-Grant is reached, and a sleep request outside Stop-Grant or Sleep. Only reset clears these flags.

Top module: `pwr_state_ctl`

## Requirements
- R1: While synchronous reset is high, and after it is released, the state output reads Normal, clk_en is 1 and both violation flags are 0. The state codes are 0 = Normal, 1 = HALT, 2 = Stop-Grant and 3 = Sleep.
- R2: From Normal, the state moves to HALT at the next clock edge only when every bit of `halted` is 1. If only some of the bits are 1, the state stays Normal.
- R3: In HALT, a high `wake` returns the state to Normal at the next edge.
- R4: While `stpclk_req` stays high, a lane is granted DELAY edges after the edge that samples its `ack_resp` bit. With a single lane pending, the state reads Stop-Grant after exactly DELAY edges and still reads Normal after DELAY-1 edges.
- R5: With more than one lane, Stop-Grant is entered only when the lane acknowledged last is granted. That is DELAY edges after its own acknowledge.
- R6: If `stpclk_req` drops before Stop-Grant is entered, every lane timer and grant is cleared. A fresh acknowledge is then needed, and the full DELAY count runs again.
- R7: A fall of `stpclk_req` while the state is Normal or HALT sets `viol_stpclk`. A fall in Stop-Grant returns the state to Normal at the next edge and leaves the flag at 0.
- R8: In Stop-Grant, a high `sleep_req` moves the state to Sleep at the next edge. clk_en is 0 from that same edge for as long as Sleep lasts.
- R9: A high `sleep_req` while the state is Normal or HALT does not lead to Sleep, and it sets `viol_sleep`.
- R10: In Sleep, dropping `sleep_req` returns the state to Stop-Grant at the next edge, with clk_en back at 1.
- R11: Both violation flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stpclk_req | input | 1 | Stop-clock request, active high |
| sleep_req | input | 1 | Sleep request, active high |
| halted | input | NLP | Per-lane indication that a halt or monitor-wait instruction was executed |
| ack_resp | input | NLP | Per-lane pulse at the response phase of the stop-grant acknowledge cycle |
| wake | input | 1 | Returns HALT to Normal |
| state_o | output | 2 | Current state code |
| clk_en | output | 1 | Internal clock-gate enable, 0 in Sleep |
| viol_stpclk | output | 1 | Sticky flag: stop-clock request released before Stop-Grant |
| viol_sleep | output | 1 | Sticky flag: sleep request outside Stop-Grant or Sleep |

## Verification
Several properties are checked on every cycle:
- Sleep is reached only from Stop-Grant.
- HALT is entered only with all halt bits set.
- Stop-Grant is never left to Normal while the stop-clock request is held.
- A lane grant rises only out of a running timer.
- A withdrawn request clears the timers.
- The violation flags never fall.

Only the directed scenarios can show the following:
- The exact edge on which Stop-Grant begins, for one acknowledge and for staggered acknowledges.
- The restart of the count after a withdrawal.
- The value of clk_en across a sleep episode.
- That each misuse sets its own flag.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL    = 2'd0,
      ST_HALT      = 2'd1,
      ST_STOPGRANT = 2'd2,
      ST_SLEEP     = 2'd3
   } pwr_state_t;
endpackage

// File: rtl/pwr_lp_timer.sv
module pwr_lp_timer #(
   parameter int DELAY = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic stpclk_i,
   input  logic ack_i,
   output logic done_o
);
   localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   logic          run_q;
   logic          granted_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !stpclk_i) begin
         run_q     <= 1'b0;
         granted_q <= 1'b0;
         cnt_q     <= '0;
      end else if (run_q) begin
         if (cnt_q == LAST) begin
            run_q     <= 1'b0;
            granted_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (ack_i && !granted_q) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end
   end

   // granted now, or granted at the coming edge
   assign done_o = granted_q | (run_q && (cnt_q == LAST));

   // R4: a grant appears only at the end of a running count
   a_r4_grant_from_run: assert property (@(posedge clk) disable iff (rst)
      $rose(granted_q) |-> $past(run_q));

   // R6: a withdrawn request leaves no count and no grant
   a_r6_withdraw_clears: assert property (@(posedge clk) disable iff (rst)
      !stpclk_i |=> (!granted_q && !run_q));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import pwr_state_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       stpclk_i,
   input  logic       sleep_i,
   input  logic       all_halt_i,
   input  logic       wake_i,
   input  logic       all_done_i,
   output pwr_state_t state_o,
   output logic       clk_en_o,
   output logic       viol_stpclk_o,
   output logic       viol_sleep_o
);
   pwr_state_t st_q, st_d;
   logic       stpclk_q;
   logic       early_rel;
   logic       bad_sleep;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_NORMAL: begin
            if (stpclk_i && all_done_i)  st_d = ST_STOPGRANT;
            else if (all_halt_i)         st_d = ST_HALT;
         end
         ST_HALT: begin
            if (stpclk_i && all_done_i)  st_d = ST_STOPGRANT;
            else if (wake_i)             st_d = ST_NORMAL;
         end
         ST_STOPGRANT: begin
            if (!stpclk_i)               st_d = ST_NORMAL;
            else if (sleep_i)            st_d = ST_SLEEP;
         end
         ST_SLEEP: begin
            if (!sleep_i)                st_d = ST_STOPGRANT;
         end
         default:                        st_d = ST_NORMAL;
      endcase
   end

   assign early_rel = stpclk_q && !stpclk_i &&
                      (st_q == ST_NORMAL || st_q == ST_HALT);
   assign bad_sleep = sleep_i && (st_q == ST_NORMAL || st_q == ST_HALT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q          <= ST_NORMAL;
         clk_en_o      <= 1'b1;
         stpclk_q      <= 1'b0;
         viol_stpclk_o <= 1'b0;
         viol_sleep_o  <= 1'b0;
      end else begin
         st_q          <= st_d;
         clk_en_o      <= (st_d != ST_SLEEP);
         stpclk_q      <= stpclk_i;
         viol_stpclk_o <= viol_stpclk_o | early_rel;
         viol_sleep_o  <= viol_sleep_o | bad_sleep;
      end
   end

   assign state_o = st_q;

   // R8: Sleep is reachable only out of Stop-Grant or Sleep
   a_r8_sleep_entry: assert property (@(posedge clk) disable iff (rst)
      (st_q != ST_STOPGRANT && st_q != ST_SLEEP) |=> (st_q != ST_SLEEP));

   // R2: HALT entered from Normal only with every lane halted
   a_r2_halt_all: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_HALT && $past(st_q) == ST_NORMAL) |-> $past(all_halt_i));

   // R7: Stop-Grant is kept while the request is held
   a_r7_hold_sg: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_STOPGRANT && stpclk_i) |=> (st_q != ST_NORMAL));

   // R11: violation flags never clear outside reset
   a_r11_sticky_stp: assert property (@(posedge clk) disable iff (rst)
      !$fell(viol_stpclk_o));
   a_r11_sticky_slp: assert property (@(posedge clk) disable iff (rst)
      !$fell(viol_sleep_o));
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
   import pwr_state_pkg::*;
#(
   parameter int NLP   = 2,
   parameter int DELAY = 20
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           stpclk_req,
   input  logic           sleep_req,
   input  logic [NLP-1:0] halted,
   input  logic [NLP-1:0] ack_resp,
   input  logic           wake,
   output logic [1:0]     state_o,
   output logic           clk_en,
   output logic           viol_stpclk,
   output logic           viol_sleep
);
   if (NLP < 1) begin : g_bad_nlp
      $error("NLP must be at least 1");
   end
   if (DELAY < 2) begin : g_bad_delay
      $error("DELAY must be at least 2");
   end

   logic [NLP-1:0] lane_done;
   pwr_state_t     st;

   for (genvar i = 0; i < NLP; i++) begin : g_lane
      pwr_lp_timer #(.DELAY(DELAY)) u_tmr (
         .clk      (clk),
         .rst      (rst),
         .stpclk_i (stpclk_req),
         .ack_i    (ack_resp[i]),
         .done_o   (lane_done[i])
      );
   end

   pwr_fsm u_fsm (
      .clk           (clk),
      .rst           (rst),
      .stpclk_i      (stpclk_req),
      .sleep_i       (sleep_req),
      .all_halt_i    (&halted),
      .wake_i        (wake),
      .all_done_i    (&lane_done),
      .state_o       (st),
      .clk_en_o      (clk_en),
      .viol_stpclk_o (viol_stpclk),
      .viol_sleep_o  (viol_sleep)
   );

   assign state_o = st;

   // R5: Stop-Grant is entered only when every lane is done
   a_r5_all_lanes: assert property (@(posedge clk) disable iff (rst)
      (st == ST_STOPGRANT && $past(st) != ST_STOPGRANT && $past(st) != ST_SLEEP)
         |-> $past(&lane_done));
endmodule

// File: tb/pwr_state_ctl_test.sv
module pwr_state_ctl_test;
   localparam int NLP   = 2;
   localparam int DELAY = 20;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           stpclk_req = 1'b0;
   logic           sleep_req = 1'b0;
   logic [NLP-1:0] halted = '0;
   logic [NLP-1:0] ack_resp = '0;
   logic           wake = 1'b0;
   logic [1:0]     state_o;
   logic           clk_en;
   logic           viol_stpclk;
   logic           viol_sleep;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pwr_state_ctl #(.NLP(NLP), .DELAY(DELAY)) uut (
      .clk(clk), .rst(rst), .stpclk_req(stpclk_req), .sleep_req(sleep_req),
      .halted(halted), .ack_resp(ack_resp), .wake(wake), .state_o(state_o),
      .clk_en(clk_en), .viol_stpclk(viol_stpclk), .viol_sleep(viol_sleep)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; stpclk_req = 0; sleep_req = 0; halted = '0; ack_resp = '0; wake = 0;
      step(2);
      rst = 1'b0;
      step(1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 state", state_o, 0);
      chk("R1 clk_en", clk_en, 1);
      chk("R1 viol_stpclk", viol_stpclk, 0);
      chk("R1 viol_sleep", viol_sleep, 0);
   endtask

   task automatic t_halt();
      do_reset();
      halted = 2'b01; step(1);
      chk("R2 partial halt stays Normal", state_o, 0);
      halted = 2'b11; step(1);
      chk("R2 all halted enters HALT", state_o, 1);
      halted = 2'b00; step(2);
      chk("R3 HALT held without wake", state_o, 1);
      wake = 1; step(1); wake = 0;
      chk("R3 wake returns Normal", state_o, 0);
   endtask

   // reach Stop-Grant with both lanes acked together
   task automatic enter_sg();
      stpclk_req = 1; ack_resp = 2'b11; step(1); ack_resp = 2'b00;
      step(DELAY - 1);
      chk("R4 Normal one edge before entry", state_o, 0);
      step(1);
      chk("R4 Stop-Grant after DELAY edges", state_o, 2);
   endtask

   task automatic t_stopgrant();
      do_reset();
      enter_sg();
      stpclk_req = 0; step(1);
      chk("R7 release in Stop-Grant returns Normal", state_o, 0);
      chk("R7 legal release no flag", viol_stpclk, 0);
   endtask

   task automatic t_staggered();
      do_reset();
      stpclk_req = 1; ack_resp = 2'b01; step(1); ack_resp = 2'b00;
      step(4);
      ack_resp = 2'b10; step(1); ack_resp = 2'b00;
      step(DELAY - 1);
      chk("R5 waits for later lane", state_o, 0);
      step(1);
      chk("R5 entry after later lane", state_o, 2);
   endtask

   task automatic t_restart();
      do_reset();
      stpclk_req = 1; ack_resp = 2'b11; step(1); ack_resp = 2'b00;
      step(10);
      stpclk_req = 0; step(1);
      chk("R7 early release flag", viol_stpclk, 1);
      stpclk_req = 1; step(15);
      chk("R6 no entry without fresh ack", state_o, 0);
      ack_resp = 2'b11; step(1); ack_resp = 2'b00;
      step(DELAY - 1);
      chk("R6 full count reruns", state_o, 0);
      step(1);
      chk("R6 entry after fresh count", state_o, 2);
      step(3);
      chk("R11 viol_stpclk stays set", viol_stpclk, 1);
   endtask

   task automatic t_sleep();
      do_reset();
      enter_sg();
      sleep_req = 1; step(1);
      chk("R8 Sleep entered", state_o, 3);
      chk("R8 clk_en low in Sleep", clk_en, 0);
      step(3);
      chk("R8 Sleep held", state_o, 3);
      chk("R8 clk_en stays low", clk_en, 0);
      sleep_req = 0; step(1);
      chk("R10 back to Stop-Grant", state_o, 2);
      chk("R10 clk_en high again", clk_en, 1);
      chk("R9 legal sleep no flag", viol_sleep, 0);
   endtask

   task automatic t_bad_sleep();
      do_reset();
      sleep_req = 1; step(1);
      chk("R9 no Sleep from Normal", state_o, 0);
      chk("R9 flag from Normal", viol_sleep, 1);
      sleep_req = 0;
      do_reset();
      halted = 2'b11; step(1);
      sleep_req = 1; step(1);
      chk("R9 no Sleep from HALT", state_o, 1);
      chk("R9 flag from HALT", viol_sleep, 1);
      sleep_req = 0; halted = 2'b00; step(3);
      chk("R11 viol_sleep stays set", viol_sleep, 1);
      chk("R9 clk_en unaffected", clk_en, 1);
   endtask

   initial begin
      t_reset();
      t_halt();
      t_stopgrant();
      t_staggered();
      t_restart();
      t_sleep();
      t_bad_sleep();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule